// File: doc/BRIEF.md
# Widescreen Signalling Bit Serializer

This block turns the widescreen signalling payload of one video line into a serial bit stream. A 14-bit data word and a 6-bit check word are presented as static configuration inputs. When the block is enabled and a start strobe arrives, it captures both words into an internal shift register. It then presents one bit at a time on its serial output, advancing on each bit-period tick that an external timing generator supplies.

The standard select decides the frame length. For the 525-line standard the six check bits follow the data bits, for 20 bit periods in total. For the 625-line standard only the 14 data bits are sent, and the check word is not used. Both fields leave least-significant bit first. A valid flag marks the transfer, and a one-clock done pulse marks its normal end. The line timing that issues the start strobe, and the analog shaping of the bits, sit outside the block.

Top module: `wss_serializer`

## Requirements
- R1: After reset `ser_valid`, `ser_bit` and `done` are all low.
- R2: A `start` high while `enable` is high and no transfer is running begins a transfer. On the next clock `ser_valid` is high and `ser_bit` shows data bit 0.
- R3: Data bits leave least-significant first, one per `bit_tick`. A bit is held on `ser_bit` until the clock edge at which `bit_tick` is sampled high. Clocks without a tick do not change it.
- R4: With `mode_ntsc` = 1 the six check bits follow the 14 data bits, bit 0 of `wss_crc` first, for 20 bit periods.
- R5: With `mode_ntsc` = 0 the frame ends after 14 bit periods, and the value of `wss_crc` has no effect on the output.
- R6: At the clock edge that consumes the last bit period, `ser_valid` falls and `done` goes high for exactly one clock. `done` is low at all other times.
- R7: `wss_data`, `wss_crc` and `mode_ntsc` are captured when a transfer is accepted. Changes to them during the transfer do not alter the bits sent or the frame length.
- R8: A `start` strobe seen while a transfer is running is ignored. The running frame goes on unchanged and no new frame begins.
- R9: With `enable` low nothing is sent: `start` is ignored. If `enable` drops during a transfer, the transfer ends at the next clock with `ser_valid` low and no `done` pulse.
- R10: `ser_bit` is low whenever `ser_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows transfers; low stops any transfer in progress |
| mode_ntsc | input | 1 | 1 = 525-line frame (data + check), 0 = 625-line frame (data only) |
| wss_data | input | 14 | Payload word, sent LSB first |
| wss_crc | input | 6 | Check word, sent LSB first after the data in 525-line mode |
| start | input | 1 | Request to begin a frame |
| bit_tick | input | 1 | One-clock strobe that ends the current bit period |
| ser_bit | output | 1 | Serial bit currently being sent |
| ser_valid | output | 1 | High while a frame is being sent (busy) |
| done | output | 1 | One-clock pulse after the last bit period of a frame |

## Verification
A wrong shift-register value shows as a bad `ser_bit` at the first bit period it reaches. The bench compares every bit against a frame rebuilt from the words it applied at the start, so such an error shows within one tick. A bit counter that is off by one moves the falling edge of `ser_valid` and the `done` pulse by one tick. Loading the wrong length for the standard moves them by six ticks. The bench checks that edge on every frame. A control state that failed to capture its inputs, or that accepted a second start, changes the remaining bits as soon as the bench disturbs the inputs in mid-frame.

// File: rtl/wss_pkg.sv
package wss_pkg;
    localparam int unsigned WSS_DATA_W = 14;
    localparam int unsigned WSS_CRC_W  = 6;

    typedef enum logic {
        STD_625 = 1'b0,
        STD_525 = 1'b1
    } wss_std_e;
endpackage

// File: rtl/wss_frame_builder.sv
module wss_frame_builder #(
    parameter int unsigned DATA_W  = wss_pkg::WSS_DATA_W,
    parameter int unsigned CRC_W   = wss_pkg::WSS_CRC_W,
    localparam int unsigned FRAME_W = DATA_W + CRC_W,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               mode_ntsc,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CRC_W-1:0]   crc_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o
);
    import wss_pkg::*;

    wss_std_e std_sel;
    assign std_sel = wss_std_e'(mode_ntsc);

    // Frame word: data in the low bits, check bits above, both LSB first
    for (genvar k = 0; k < FRAME_W; k++) begin : g_bit
        if (k < DATA_W) begin : g_data
            assign frame_o[k] = data_i[k];
        end else begin : g_crc
            assign frame_o[k] = (std_sel == STD_525) & crc_i[k-DATA_W];
        end
    end

    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W);

    always_comb begin
        len_o = (std_sel == STD_525) ? LEN_LONG : LEN_SHORT;
    end
endmodule

// File: rtl/wss_shift_engine.sv
module wss_shift_engine #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame_i,
    input  logic         shift,
    input  logic         clear,
    output logic         lsb_o
);
    typedef struct packed {
        logic [W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.sh = '0;
        end else if (load) begin
            st_d.sh = frame_i;
        end else if (shift) begin
            st_d.sh = {1'b0, st_q.sh[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsb_o = st_q.sh[0];

    // R7: a load captures the whole presented frame word
    p_load_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (st_q.sh == $past(frame_i)));

    // R3: shifting brings zeros into the top, so stale bits never reappear
    p_shift_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && !clear) |=> (st_q.sh[W-1] == 1'b0));

    // R10: a clear leaves the register empty
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.sh == '0));
endmodule

// File: rtl/wss_bit_counter.sv
module wss_bit_counter #(
    parameter int unsigned MAX_LEN = 20,
    localparam int unsigned CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dec,
    input  logic             clear,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = len_i;
        end else if (dec && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.cnt == CNT_W'(1));

    // R6: the control never counts past zero
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (st_q.cnt != '0));

    // R4: remaining count stays within the longest frame
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_LEN));

    // R5: a frame is never loaded with zero length
    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len_i != '0));
endmodule

// File: rtl/wss_serializer.sv
module wss_serializer #(
    parameter int unsigned DATA_W  = wss_pkg::WSS_DATA_W,
    parameter int unsigned CRC_W   = wss_pkg::WSS_CRC_W,
    localparam int unsigned FRAME_W = DATA_W + CRC_W,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_ntsc,
    input  logic [DATA_W-1:0] wss_data,
    input  logic [CRC_W-1:0]  wss_crc,
    input  logic              start,
    input  logic              bit_tick,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              done
);
    typedef struct packed {
        logic busy;
        logic done;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;
    logic               accept, abort, step, finish, last_bit, head_bit;

    wss_frame_builder #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_build (
        .mode_ntsc (mode_ntsc),
        .data_i    (wss_data),
        .crc_i     (wss_crc),
        .frame_o   (frame),
        .len_o     (frame_len)
    );

    always_comb begin
        accept = enable & start & ~st_q.busy;
        abort  = st_q.busy & ~enable;
        step   = st_q.busy & enable & bit_tick;
        finish = step & last_bit;

        st_d      = st_q;
        st_d.done = finish;
        if (accept) begin
            st_d.busy = 1'b1;
        end else if (abort || finish) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wss_shift_engine #(.W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame_i (frame),
        .shift   (step),
        .clear   (abort | finish),
        .lsb_o   (head_bit)
    );

    wss_bit_counter #(.MAX_LEN(FRAME_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .len_i  (frame_len),
        .dec    (step),
        .clear  (abort | finish),
        .last_o (last_bit)
    );

    assign ser_valid = st_q.busy;
    assign ser_bit   = st_q.busy & head_bit;
    assign done      = st_q.done;

    // R6: done lasts a single clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only follows the end of an active frame
    p_done_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ser_valid) && !ser_valid));

    // R8: a running frame without a tick keeps going, whatever start does
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && enable && !bit_tick) |=> ser_valid);

    // R3: no tick, no change of the serial bit
    p_bit_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && enable && !bit_tick) |=> $stable(ser_bit));

    // R9: disabled means nothing is sent on the next clock
    p_disable_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ser_valid);

    // R10: idle output is low
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_bit);

    // R2: an accepted start raises valid on the next clock
    p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start && !ser_valid) |=> ser_valid);
endmodule

// File: tb/wss_serializer_test.sv
`timescale 1ns/1ps
module wss_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode_ntsc = 1'b0;
    logic [13:0] wss_data = '0;
    logic [5:0]  wss_crc = 6'h3F;
    logic        start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ser_bit, ser_valid, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wss_serializer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_ntsc(mode_ntsc),
        .wss_data(wss_data), .wss_crc(wss_crc), .start(start),
        .bit_tick(bit_tick), .ser_bit(ser_bit), .ser_valid(ser_valid), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int exp_len(input bit ntsc);
        return ntsc ? 20 : 14;
    endfunction

    function automatic bit exp_bit(input bit ntsc, input logic [13:0] d,
                                   input logic [5:0] c, input int i);
        if (i < 14) return d[i];
        if (ntsc && i < 20) return c[i-14];
        return 1'b0;
    endfunction

    // Runs one frame; disturb changes inputs and pulses start mid-frame (R7, R8)
    task automatic run_frame(input bit ntsc, input logic [13:0] d, input logic [5:0] c,
                             input bit disturb, input int maxgap);
        int len;
        @(negedge clk);
        mode_ntsc = ntsc; wss_data = d; wss_crc = c;
        enable = 1'b1; start = 1'b1; bit_tick = 1'b0;
        @(negedge clk);
        start = 1'b0;
        len = exp_len(ntsc);
        for (int i = 0; i < len; i++) begin
            int gap;
            bit eb;
            eb = exp_bit(ntsc, d, c, i);
            chk(ser_valid == 1'b1, "R2 valid during frame", int'(ser_valid), 1);
            chk(ser_bit == eb, (i < 14) ? "R3 data bit" : "R4 crc bit", int'(ser_bit), int'(eb));
            chk(done == 1'b0, "R6 no early done", int'(done), 0);
            gap = $urandom_range(0, maxgap);
            for (int g = 0; g < gap; g++) begin
                if (disturb) begin
                    wss_data  = 14'($urandom);
                    wss_crc   = 6'($urandom);
                    mode_ntsc = 1'($urandom);
                    start     = 1'($urandom);
                end
                @(negedge clk);
                chk(ser_bit == eb, "R7 R8 bit held against input changes", int'(ser_bit), int'(eb));
                chk(ser_valid == 1'b1, "R8 frame continues", int'(ser_valid), 1);
            end
            bit_tick = 1'b1; start = 1'b0;
            @(negedge clk);
            bit_tick = 1'b0;
        end
        chk(ser_valid == 1'b0, ntsc ? "R4 valid ends after 20" : "R5 valid ends after 14",
            int'(ser_valid), 0);
        chk(done == 1'b1, "R6 done after last bit", int'(done), 1);
        chk(ser_bit == 1'b0, "R10 idle bit low", int'(ser_bit), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one clock", int'(done), 0);
        chk(ser_valid == 1'b0, "R8 no second frame", int'(ser_valid), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(ser_valid == 1'b0, "R1 reset valid", int'(ser_valid), 0);
        chk(ser_bit == 1'b0, "R1 reset bit", int'(ser_bit), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;

        // R9: start while disabled is ignored
        @(negedge clk);
        start = 1'b1; enable = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(ser_valid == 1'b0, "R9 start ignored when disabled", int'(ser_valid), 0);
            chk(ser_bit == 1'b0, "R10 idle bit low", int'(ser_bit), 0);
        end
        start = 1'b0;

        // Directed corners
        run_frame(1'b1, 14'h2AAA, 6'h3F, 1'b0, 0);   // R4 back-to-back ticks, check word all ones
        run_frame(1'b0, 14'h1555, 6'h3F, 1'b0, 2);   // R5 check word ignored
        run_frame(1'b0, 14'h3FFF, 6'h00, 1'b1, 3);   // R7 R8
        run_frame(1'b1, 14'h0001, 6'h20, 1'b1, 3);   // R4 check MSB last

        // R9: abort by dropping enable mid-frame
        @(negedge clk);
        mode_ntsc = 1'b1; wss_data = 14'h3FFF; enable = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
        end
        chk(ser_valid == 1'b1, "R9 running before abort", int'(ser_valid), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(ser_valid == 1'b0, "R9 abort ends frame", int'(ser_valid), 0);
        chk(done == 1'b0, "R9 no done on abort", int'(done), 0);
        chk(ser_bit == 1'b0, "R10 bit low after abort", int'(ser_bit), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 no done after abort", int'(done), 0);

        // Constrained random frames
        for (int n = 0; n < 30; n++) begin
            run_frame(1'($urandom), 14'($urandom), 6'($urandom), 1'($urandom), 4);
        end

        repeat (2) @(negedge clk);
        report();
    end
endmodule